// File: doc/BRIEF.md
# Four-Class Multifunction ALU

This block is the arithmetic and logic unit of a small load/store processor core. It is purely combinational. It takes two operands and a short immediate, and returns one result word together with a zero flag and an overflow flag. The result comes from one of four classes, chosen by a 2-bit class select:

- an upper-immediate load,
- a signed set-less-than,
- add or subtract,
- one of four bitwise logic functions.

A 1-bit add/subtract select and a 2-bit logic select refine the choice. The decoder that drives these selects sits outside the block.

Every class is built on a single adder/subtractor. The signed compare reads the sign of the difference, corrected by the overflow of that difference. The zero flag tests the adder output, so a branch-if-equal can use it by selecting subtract. A small control decoder turns the selects into one-hot strobes. A datapath then combines the adder, the logic unit and the immediate placement under those strobes.

Top module: `multiclass_alu`

## Requirements
- R1: With class select 0, the result holds the immediate in its upper IMM_W bits (bits 31:16 by default) and zero in every lower bit.
- R2: With class select 1 and subtract select 1, the result is 1 when xIn is less than yIn as two's-complement numbers and 0 otherwise, with every bit above bit 0 zero. This holds even when the difference overflows.
- R3: With class select 2, the result is xIn + yIn modulo 2^WIDTH when subtract select is 0, and xIn - yIn modulo 2^WIDTH when it is 1.
- R4: With class select 3, logic select 0, 1, 2 and 3 give the bitwise AND, OR, XOR and NOR of xIn and yIn.
- R5: In every class, the zero flag is 1 exactly when the adder output is all zeros. That output is xIn + yIn under subtract select 0 and xIn - yIn under subtract select 1.
- R6: The overflow flag is 1 exactly when the class select is 2 and the selected add or subtract overflows as a signed operation. It is 0 in every other class.
- R7: The block holds no state: the outputs settle within the cycle the inputs change, and equal inputs always give equal outputs, whatever came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| xIn | input | WIDTH | First operand |
| yIn | input | WIDTH | Second operand |
| immIn | input | IMM_W | Immediate for the upper-immediate class |
| fnClass | input | 2 | Class select: 0 upper immediate, 1 set-less-than, 2 arithmetic, 3 logic |
| subSel | input | 1 | 0 adds, 1 subtracts |
| logicSel | input | 2 | 0 AND, 1 OR, 2 XOR, 3 NOR |
| result | output | WIDTH | Selected result |
| zeroFlag | output | 1 | Adder output is all zeros |
| ovflFlag | output | 1 | Signed overflow in the arithmetic class |

## Verification
No register lies between any input and any output, so each result and both flags are due in the same cycle as the stimulus that causes them.

The bench drives new inputs on the falling clock edge. It samples one nanosecond later, well before the next rising edge, so each check sees exactly the outputs of the inputs just applied.

The R7 checks replay an earlier input pattern after unrelated traffic. The replayed pattern must give the same outputs as before.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    CLS_UPPER = 2'd0,
    CLS_LESS  = 2'd1,
    CLS_ARITH = 2'd2,
    CLS_BITOP = 2'd3
  } fnClass_t;

  typedef enum logic [1:0] {
    BIT_AND = 2'd0,
    BIT_OR  = 2'd1,
    BIT_XOR = 2'd2,
    BIT_NOR = 2'd3
  } bitOp_t;

  typedef struct packed {
    logic   pickUpper;
    logic   pickLess;
    logic   pickArith;
    logic   pickBitop;
    logic   doSub;
    bitOp_t bitOp;
  } aluStrobes_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             doSub,
  output logic [WIDTH-1:0] sumOut,
  output logic             sOvfl,
  output logic             lessOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bOp;
  logic [WIDTH:0]   wideSum;

  always_comb begin
    bOp     = doSub ? ~bIn : bIn;
    wideSum = {1'b0, aIn} + {1'b0, bOp} + {{WIDTH{1'b0}}, doSub};
    sumOut  = wideSum[MSB:0];
    sOvfl   = (aIn[MSB] == bOp[MSB]) && (sumOut[MSB] != aIn[MSB]);
    lessOut = sumOut[MSB] ^ sOvfl;
  end

  // R2: equal operands under subtract are never less-than
  always_comb begin
    if (doSub && (aIn == bIn)) begin
      eq_not_less_chk: assert (!lessOut && (sumOut == '0))
        else $error("equal operands flagged less or nonzero difference");
    end
  end
endmodule

// File: rtl/alu_bitop.sv
module alu_bitop
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  bitOp_t           bitOp,
  output logic [WIDTH-1:0] bitOut
);
  always_comb begin
    unique case (bitOp)
      BIT_AND: bitOut = aIn & bIn;
      BIT_OR:  bitOut = aIn | bIn;
      BIT_XOR: bitOut = aIn ^ bIn;
      default: bitOut = ~(aIn | bIn);
    endcase
  end
endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [1:0]  fnClass,
  input  logic        subSel,
  input  logic [1:0]  logicSel,
  output aluStrobes_t strobes
);
  fnClass_t cls;

  always_comb begin
    cls               = fnClass_t'(fnClass);
    strobes.pickUpper = (cls == CLS_UPPER);
    strobes.pickLess  = (cls == CLS_LESS);
    strobes.pickArith = (cls == CLS_ARITH);
    strobes.pickBitop = (cls == CLS_BITOP);
    strobes.doSub     = subSel;
    strobes.bitOp     = bitOp_t'(logicSel);
  end

  // R1: exactly one result class is picked for every select value
  always_comb begin
    sel_onehot_chk: assert ($countones({strobes.pickUpper, strobes.pickLess,
                                        strobes.pickArith, strobes.pickBitop}) == 1)
      else $error("class strobes not one-hot");
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0] xIn,
  input  logic [WIDTH-1:0] yIn,
  input  logic [IMM_W-1:0] immIn,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             ovflFlag
);
  localparam int LOW_W = WIDTH - IMM_W;

  logic [WIDTH-1:0] sumVal;
  logic [WIDTH-1:0] bitVal;
  logic [WIDTH-1:0] upperVal;
  logic             sumOvfl;
  logic             lessVal;

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .aIn(xIn), .bIn(yIn), .doSub(strobes.doSub),
    .sumOut(sumVal), .sOvfl(sumOvfl), .lessOut(lessVal)
  );

  alu_bitop #(.WIDTH(WIDTH)) u_bitop (
    .aIn(xIn), .bIn(yIn), .bitOp(strobes.bitOp), .bitOut(bitVal)
  );

  generate
    if (LOW_W > 0) begin : g_padLow
      assign upperVal = {immIn, {LOW_W{1'b0}}};
    end else begin : g_noPad
      assign upperVal = immIn[WIDTH-1:0];
    end
  endgenerate

  always_comb begin
    result = '0;
    if (strobes.pickUpper) result = upperVal;
    if (strobes.pickLess)  result = {{(WIDTH-1){1'b0}}, lessVal};
    if (strobes.pickArith) result = sumVal;
    if (strobes.pickBitop) result = bitVal;
    zeroFlag = (sumVal == '0);
    ovflFlag = strobes.pickArith & sumOvfl;
  end

  // R2: set-less-than leaves every bit above bit 0 clear
  always_comb begin
    if (strobes.pickLess) begin
      less_upper_clear_chk: assert (result[WIDTH-1:1] == '0)
        else $error("set-less-than result has upper bits set");
    end
  end

  // R6: overflow only reported in the arithmetic class
  always_comb begin
    if (ovflFlag) begin
      no_overflow_chk: assert (strobes.pickArith)
        else $error("overflow flagged outside arithmetic class");
    end
  end

  // R5: zero flag and arithmetic result agree
  always_comb begin
    if (strobes.pickArith) begin
      zero_match_chk: assert (zeroFlag == (result == '0))
        else $error("zero flag disagrees with arithmetic result");
    end
  end

  // R1: upper-immediate low bits are zero and upper bits carry the immediate
  generate
    if (LOW_W > 0) begin : g_upperChk
      always_comb begin
        if (strobes.pickUpper) begin
          upper_low_zero_chk: assert ((result[LOW_W-1:0] == '0) &&
                                      (result[WIDTH-1:LOW_W] == immIn))
            else $error("upper-immediate placement wrong");
        end
      end
    end
  endgenerate
endmodule

// File: rtl/multiclass_alu.sv
module multiclass_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0] xIn,
  input  logic [WIDTH-1:0] yIn,
  input  logic [IMM_W-1:0] immIn,
  input  logic [1:0]       fnClass,
  input  logic             subSel,
  input  logic [1:0]       logicSel,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             ovflFlag
);
  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .fnClass(fnClass), .subSel(subSel), .logicSel(logicSel), .strobes(strobes)
  );

  alu_datapath #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_datapath (
    .xIn(xIn), .yIn(yIn), .immIn(immIn), .strobes(strobes),
    .result(result), .zeroFlag(zeroFlag), .ovflFlag(ovflFlag)
  );
endmodule

// File: tb/multiclass_alu_tb.sv
module multiclass_alu_tb;
  localparam int BW = 32;
  localparam int BI = 16;
  localparam int SW = 6;
  localparam int SI = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [BW-1:0] bx, by, bres;
  logic [BI-1:0] bimm;
  logic [1:0]    bcls, blf;
  logic          bsub, bzero, bovf;

  logic [SW-1:0] sx, sy, sres;
  logic [SI-1:0] simm;
  logic [1:0]    scls, slf;
  logic          ssub, szero, sovf;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;
  string tags[4] = '{"R1", "R2", "R3", "R4"};

  multiclass_alu #(.WIDTH(BW), .IMM_W(BI)) u_dut (
    .xIn(bx), .yIn(by), .immIn(bimm), .fnClass(bcls), .subSel(bsub),
    .logicSel(blf), .result(bres), .zeroFlag(bzero), .ovflFlag(bovf)
  );

  multiclass_alu #(.WIDTH(SW), .IMM_W(SI)) u_small (
    .xIn(sx), .yIn(sy), .immIn(simm), .fnClass(scls), .subSel(ssub),
    .logicSel(slf), .result(sres), .zeroFlag(szero), .ovflFlag(sovf)
  );

  task automatic chk(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void model(input int w, input int iw, input longint x, input longint y,
                                input longint imm, input int cls, input int sub, input int lf,
                                output longint r, output bit z, output bit o);
    longint mask = (longint'(1) << w) - 1;
    longint half = longint'(1) << (w - 1);
    longint vx = (x >= half) ? x - (mask + 1) : x;
    longint vy = (y >= half) ? y - (mask + 1) : y;
    longint ar = (sub != 0) ? vx - vy : vx + vy;
    longint au = ar & mask;
    z = (au == 0);
    o = (cls == 2) && (ar >= half || ar < -half);
    case (cls)
      0: r = (imm << (w - iw)) & mask;
      1: r = (vx < vy) ? 1 : 0;
      2: r = au;
      default: case (lf)
        0: r = x & y;
        1: r = x | y;
        2: r = x ^ y;
        default: r = ~(x | y) & mask;
      endcase
    endcase
  endfunction

  task automatic checkBig(int cls, int sub, int lf, longint x, longint y, longint imm);
    longint er; bit ez, eo;
    @(negedge clk);
    bcls = 2'(cls); bsub = 1'(sub); blf = 2'(lf);
    bx = BW'(x); by = BW'(y); bimm = BI'(imm);
    #1;
    model(BW, BI, x, y, imm, cls, sub, lf, er, ez, eo);
    chk(tags[cls], longint'(bres), er);
    chk("R5", longint'(bzero), longint'(ez));
    chk("R6", longint'(bovf), longint'(eo));
  endtask

  initial begin
    #400000;
    if (!done) begin
      nErr++;
      $display("FAIL R7: watchdog expired, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    longint r1; bit z1, o1;
    bx = '0; by = '0; bimm = '0; bcls = 2'd2; bsub = 1'b0; blf = '0;
    sx = '0; sy = '0; simm = '0; scls = '0; ssub = '0; slf = '0;
    @(negedge clk); #1;
    // R3 R5 idle state: all-zero inputs add to zero
    chk("R3", longint'(bres), 0);
    chk("R5", longint'(bzero), 1);
    chk("R6", longint'(bovf), 0);

    // R1 upper immediate
    checkBig(0, 0, 0, 64'h12345678, 64'h1, 64'hABCD);
    checkBig(0, 1, 0, 64'hFFFFFFFF, 64'hFFFFFFFF, 64'hFFFF);
    // R2 signed compare, including overflowing differences
    checkBig(1, 1, 0, 64'hFFFFFFFF, 64'h1, 0);
    checkBig(1, 1, 0, 64'h1, 64'hFFFFFFFF, 0);
    checkBig(1, 1, 0, 64'h80000000, 64'h7FFFFFFF, 0);
    checkBig(1, 1, 0, 64'h7FFFFFFF, 64'h80000000, 0);
    checkBig(1, 1, 0, 64'h5, 64'h5, 0);
    // R3 R6 arithmetic corners
    checkBig(2, 0, 0, 64'h7FFFFFFF, 64'h1, 0);
    checkBig(2, 1, 0, 64'h80000000, 64'h1, 0);
    checkBig(2, 0, 0, 64'hFFFFFFFF, 64'h1, 0);
    checkBig(2, 1, 0, 64'hDEADBEEF, 64'hDEADBEEF, 0);
    checkBig(2, 0, 0, 64'h80000000, 64'h80000000, 0);
    // R4 logic functions; R6 no overflow reported outside arithmetic
    for (int lf = 0; lf < 4; lf++) begin
      checkBig(3, 0, lf, 64'hF0F0A5A5, 64'hFF00C3C3, 0);
      checkBig(3, 0, lf, 64'h7FFFFFFF, 64'h1, 0);
    end
    // R5 zero flag in logic class with equal operands under subtract
    checkBig(3, 1, 1, 64'h2468ACE0, 64'h2468ACE0, 0);

    // R7 replay after unrelated traffic gives the same outputs
    checkBig(2, 1, 0, 64'h00001000, 64'h00000FFF, 0);
    r1 = longint'(bres); z1 = bzero; o1 = bovf;
    checkBig(3, 0, 3, 64'hFFFFFFFF, 64'h0, 0);
    checkBig(0, 0, 0, 64'h1, 64'h2, 64'h7777);
    checkBig(2, 1, 0, 64'h00001000, 64'h00000FFF, 0);
    chk("R7", longint'(bres), r1);
    chk("R7", longint'(bzero), longint'(z1));
    chk("R7", longint'(bovf), longint'(o1));

    // Exhaustive sweep of the narrow instance over every operand pair
    @(negedge clk);
    for (int m = 0; m < 8; m++) begin
      int cls, sub, lf;
      cls = (m < 2) ? m : ((m < 4) ? 2 : 3);
      sub = (m == 1 || m == 3) ? 1 : 0;
      lf  = (m >= 4) ? m - 4 : 0;
      for (int a = 0; a < (1 << SW); a++) begin
        for (int b = 0; b < (1 << SW); b++) begin
          longint er; bit ez, eo;
          scls = 2'(cls); ssub = 1'(sub); slf = 2'(lf);
          sx = SW'(a); sy = SW'(b); simm = SI'(a);
          #1;
          model(SW, SI, a, b, a & 7, cls, sub, lf, er, ez, eo);
          chk(tags[cls], longint'(sres), er);
          chk("R5", longint'(szero), longint'(ez));
          chk("R6", longint'(sovf), longint'(eo));
          #1;
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule